// File: doc/BRIEF.md
# Two-Phase Accumulator Processor Core

This block is a small processor core that runs 32-bit instructions out of a byte-addressed, word-aligned memory. A program counter selects the next instruction. Each instruction is first read into an instruction register and only afterwards decoded and carried out. An instruction may touch at most one memory word. Four general registers hold working values. Besides the two forms of Move, the core offers Add, Clear, Decrement, a conditional branch that is taken on a strictly positive result, and Halt. A 4-bit flag set records sign, zero, signed overflow and carry. The conditional branch reads this flag set.

The surrounding system writes a program into memory, then pulses `start` with the program's entry address. From then on the core runs on its own until it reaches Halt. At that point it raises `halted` and stops issuing memory traffic. A new `start` pulse launches the next program.

The memory port is a plain synchronous port, not a stream. Read data comes back exactly one cycle after the address. Accepting a write takes no extra cycle. Because the port never stalls, there is no valid/ready handshake and no back-pressure to handle. The core simply holds the address steady through the wait cycle.

Top module: `seq_core`

## Requirements
- R1: While idle or halted, a `start` pulse loads the program counter with `start_addr` and clears its two low bits. `halted` goes low. On the following cycle a read is issued at that aligned address.
- R2: Every instruction passes through two phases. In the fetch phase `mem_rd` is high for one cycle at the program counter address, and the address is held for the next cycle while the returned word is captured into the instruction register. An operand read follows the same pattern. The core never issues two memory accesses in consecutive cycles for the same phase.
- R3: Every instruction that is not a taken branch leaves the program counter 4 higher than it was when that instruction was fetched.
- R4: Instruction fields are laid out as follows. Bits [31:28] hold the opcode: 0 load a register from memory, 1 store a register to memory, 2 add a memory word into a register, 3 clear a register, 4 decrement a register, 5 branch if greater than zero, 6 halt. Bits [27:26] select the register. Bit 25 selects indirect addressing. Bits [15:0] hold the absolute byte address or the branch target.
- R5: Load and store copy the 32-bit word between register and memory. N is set from bit 31 of the moved value and Z is set when that value is zero. V and C are both cleared.
- R6: Add writes register + memory back to the register. N and Z are taken from the result. C is the carry out of bit 31. V is set when both operands share a sign and the result's sign differs from it.
- R7: Clear writes zero to the register, which leaves Z=1 and N=V=C=0. Decrement computes register + 0xFFFFFFFF and writes it back. Its flags follow the same rules as Add, so C=1 exactly when the operand was nonzero and V=1 only when the operand was 0x80000000.
- R8: The branch loads the program counter from bits [15:0], with the low bits cleared, exactly when N=0 and Z=0. Otherwise execution falls through to the next sequential address. Neither the branch nor Halt changes any flag.
- R9: With bit 25 set, the memory address comes from register 2 and not from bits [15:0]. After the access, register 2 is increased by 4. If register 2 is also the data destination, the data value wins over the increment.
- R10: Halt moves the program counter 4 past the Halt instruction and raises `halted`. It keeps `halted` high and issues no memory reads or writes until the next `start`.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.
- R12: `flags` is presented as {N, Z, V, C}, MSB first. After reset, `flags`, `pc` and `halted` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted while idle or halted |
| start_addr | input | 16 | Entry byte address of the program |
| mem_addr | output | 16 | Byte address for memory access |
| mem_rd | output | 1 | Read request, data returned the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after `mem_rd` |
| halted | output | 1 | High after Halt executes |
| pc | output | 16 | Current program counter |
| flags | output | 4 | Condition flags {N, Z, V, C} |

## Verification
The embedded assertions check the cycle-level rules on every cycle. Reads and writes never overlap. The address holds steady through each wait cycle. A halted core stays silent on the bus. The flags survive a branch. Non-branch instructions step the counter by four. N and Z are never both set. The actual values only show up through the bench's programs. These cover the list-summing loop and its final total, the counter fall-through, branches taken and not taken on each flag pattern, the overflow and carry corners of Add and Decrement, and post-increment addressing including the case where register 2 is also the destination.

// File: rtl/seq_core_pkg.sv
package seq_core_pkg;

  typedef enum logic [3:0] {
    OP_LOAD  = 4'd0,
    OP_STORE = 4'd1,
    OP_ADD   = 4'd2,
    OP_CLR   = 4'd3,
    OP_DEC   = 4'd4,
    OP_BGT   = 4'd5,
    OP_HALT  = 4'd6
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_DEC
  } alu_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_FWAIT,
    ST_EXEC,
    ST_OWAIT,
    ST_HALT
  } state_e;

endpackage

// File: rtl/seq_core_alu.sv
module seq_core_alu
  import seq_core_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_mode_e       mode,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   res,
  output flags_t          fl
);
  logic [DW-1:0] rhs;
  logic [DW:0]   sum;

  always_comb begin
    rhs = (mode == ALU_DEC) ? {DW{1'b1}} : b;
    if (mode == ALU_PASS) sum = {1'b0, a};
    else                  sum = {1'b0, a} + {1'b0, rhs};
    res  = sum[DW-1:0];
    fl.n = res[DW-1];
    fl.z = (res == '0);
    fl.c = (mode != ALU_PASS) && sum[DW];
    fl.v = (mode != ALU_PASS) && (a[DW-1] == rhs[DW-1]) && (res[DW-1] != a[DW-1]);
  end
endmodule

// File: rtl/seq_core_regs.sv
module seq_core_regs #(
  parameter int DW      = 32,
  parameter int NREG    = 4,
  parameter int PTR_REG = 2,
  localparam int RW     = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RW-1:0]  raddr,
  output logic [DW-1:0]  rdata,
  output logic [DW-1:0]  ptr,
  input  logic           we_data,
  input  logic [RW-1:0]  waddr,
  input  logic [DW-1:0]  wdata,
  input  logic           we_ptr,
  input  logic [DW-1:0]  ptr_next
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  regs[g] <= '0;
      else if (we_data && waddr == RW'(g))         regs[g] <= wdata;
      else if (g == PTR_REG && we_ptr)             regs[g] <= ptr_next;
    end
  end

  assign rdata = regs[raddr];
  assign ptr   = regs[PTR_REG];
endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_core_pkg::*;
#(
  parameter int DW      = 32,
  parameter int AW      = 16,
  parameter int NREG    = 4,
  parameter int PTR_REG = 2,
  parameter int STEP    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   start_addr,
  output logic [15:0]   mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          halted,
  output logic [15:0]   pc,
  output logic [3:0]    flags
);
  localparam int RW     = $clog2(NREG);
  localparam int OP_LSB = DW - 4;
  localparam int RG_LSB = OP_LSB - RW;
  localparam int IND_B  = RG_LSB - 1;
  localparam int ALIGN  = $clog2(STEP);

  state_e         state;
  logic [AW-1:0]  pc_q;
  logic [DW-1:0]  ir;
  flags_t         fl_q;

  op_e            op;
  logic [RW-1:0]  rsel;
  logic           ind;
  logic [AW-1:0]  target, ea, pc_inc;
  logic [DW-1:0]  reg_rd, ptr_val, alu_a, alu_b, alu_res;
  alu_mode_e      alu_mode;
  flags_t         alu_fl;
  logic           reg_we, ptr_we, fl_we;

  assign op     = op_e'(ir[DW-1:OP_LSB]);
  assign rsel   = ir[OP_LSB-1:RG_LSB];
  assign ind    = ir[IND_B];
  assign target = {ir[AW-1:ALIGN], {ALIGN{1'b0}}};
  assign ea     = ind ? ptr_val[AW-1:0] : ir[AW-1:0];
  assign pc_inc = pc_q + AW'(STEP);

  seq_core_regs #(.DW(DW), .NREG(NREG), .PTR_REG(PTR_REG)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .raddr    (rsel),
    .rdata    (reg_rd),
    .ptr      (ptr_val),
    .we_data  (reg_we),
    .waddr    (rsel),
    .wdata    (alu_res),
    .we_ptr   (ptr_we),
    .ptr_next (ptr_val + DW'(STEP))
  );

  seq_core_alu #(.DW(DW)) u_alu (
    .mode (alu_mode),
    .a    (alu_a),
    .b    (alu_b),
    .res  (alu_res),
    .fl   (alu_fl)
  );

  always_comb begin
    alu_mode = ALU_PASS;
    alu_a    = reg_rd;
    alu_b    = mem_rdata;
    unique case (op)
      OP_LOAD: alu_a = mem_rdata;
      OP_ADD:  alu_mode = ALU_ADD;
      OP_CLR:  alu_a = '0;
      OP_DEC:  alu_mode = ALU_DEC;
      default: ;
    endcase
  end

  always_comb begin
    reg_we = 1'b0;
    ptr_we = 1'b0;
    fl_we  = 1'b0;
    if (state == ST_OWAIT) begin
      reg_we = 1'b1;
      fl_we  = 1'b1;
      ptr_we = ind;
    end else if (state == ST_EXEC) begin
      unique case (op)
        OP_CLR, OP_DEC: begin reg_we = 1'b1; fl_we = 1'b1; end
        OP_STORE:       begin fl_we = 1'b1; ptr_we = ind; end
        default: ;
      endcase
    end
  end

  always_comb begin
    mem_addr = pc_q;
    if (state == ST_EXEC || state == ST_OWAIT) mem_addr = ea;
  end
  assign mem_rd    = (state == ST_FETCH) ||
                     (state == ST_EXEC && (op == OP_LOAD || op == OP_ADD));
  assign mem_wr    = (state == ST_EXEC) && (op == OP_STORE);
  assign mem_wdata = reg_rd;
  assign halted    = (state == ST_HALT);
  assign pc        = pc_q;
  assign flags     = fl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pc_q  <= '0;
      ir    <= '0;
      fl_q  <= '0;
    end else begin
      if (fl_we) fl_q <= alu_fl;
      unique case (state)
        ST_IDLE, ST_HALT: if (start) begin
          pc_q  <= {start_addr[AW-1:ALIGN], {ALIGN{1'b0}}};
          state <= ST_FETCH;
        end
        ST_FETCH: state <= ST_FWAIT;
        ST_FWAIT: begin
          ir    <= mem_rdata;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          state <= ST_FETCH;
          pc_q  <= pc_inc;
          unique case (op)
            OP_LOAD, OP_ADD: begin state <= ST_OWAIT; pc_q <= pc_q; end
            OP_BGT:  if (!fl_q.n && !fl_q.z) pc_q <= target;
            OP_HALT: state <= ST_HALT;
            default: ;
          endcase
        end
        ST_OWAIT: begin
          pc_q  <= pc_inc;
          state <= ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R11
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FWAIT) |-> ($stable(mem_addr) && !mem_rd)); // R2
  AST_OPND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OWAIT) |-> ($stable(mem_addr) && !mem_rd && !mem_wr)); // R2
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr)); // R10
  AST_BRANCH_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && (op == OP_BGT || op == OP_HALT)) |=> $stable(flags)); // R8
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OWAIT) |=> (pc == $past(pc) + 16'(STEP))); // R3
  AST_NZ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags[3] && flags[2])); // R5
endmodule

// File: tb/test_seq_core.sv
module test_seq_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_addr = '0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, halted;
  logic [31:0] mem_wdata, mem_rdata;
  logic [15:0] pc;
  logic [3:0]  flags;

  int total = 0;
  int bad = 0;
  logic [31:0] mem [0:511];
  logic [47:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_core i_seq_core (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted), .pc(pc), .flags(flags)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[10:2]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[10:2]];
  end

  function automatic logic [31:0] enc(input int op, input int rg, input bit ind,
                                      input logic [15:0] a);
    return {4'(op), 2'(rg), ind, 9'd0, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_write(input logic [15:0] a, input logic [31:0] d);
    exp_q.push_back({a, d});
  endtask

  // scoreboard monitor: every store is compared to the next expected item
  always @(negedge clk) begin
    if (rst_n && mem_wr) begin
      logic [47:0] e;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R5/R8 store: actual=%h:%h expected=none", mem_addr, mem_wdata);
      end else begin
        e = exp_q.pop_front();
        if ({mem_addr, mem_wdata} !== e) begin
          bad++;
          $display("FAIL R5 store: actual=%h:%h expected=%h:%h",
                   mem_addr, mem_wdata, e[47:32], e[31:0]);
        end
      end
    end
  end

  task automatic run(input logic [15:0] entry, output logic first_rd,
                     output logic [15:0] first_addr);
    int n;
    @(negedge clk);
    start = 1'b1;
    start_addr = entry;
    @(negedge clk);
    start = 1'b0;
    first_rd = mem_rd;
    first_addr = mem_addr;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) begin
      total++; bad++;
      $display("FAIL R10 watchdog: actual=running expected=halted");
    end
  endtask

  initial begin
    logic        frd;
    logic [15:0] fad, pc_h;
    for (int i = 0; i < 512; i++) mem[i] = '0;
    // program A: list sum at 0x000
    mem[0]  = enc(0, 1, 0, 16'h100);
    mem[1]  = enc(0, 2, 0, 16'h108);
    mem[2]  = enc(3, 0, 0, 16'h0);
    mem[3]  = enc(2, 0, 1, 16'h0);
    mem[4]  = enc(4, 1, 0, 16'h0);
    mem[5]  = enc(5, 0, 0, 16'h00C);
    mem[6]  = enc(1, 0, 0, 16'h104);
    mem[7]  = enc(1, 2, 0, 16'h10C);
    mem[8]  = enc(6, 0, 0, 16'h0);
    // program B at 0x040
    mem[16] = enc(0, 3, 0, 16'h140);
    mem[17] = enc(2, 3, 0, 16'h144);
    mem[18] = enc(5, 0, 0, 16'h000);
    mem[19] = enc(6, 0, 0, 16'h0);
    // program C at 0x060
    mem[24] = enc(0, 0, 0, 16'h148);
    mem[25] = enc(1, 0, 0, 16'h150);
    mem[26] = enc(2, 0, 0, 16'h14C);
    mem[27] = enc(5, 0, 0, 16'h000);
    mem[28] = enc(6, 0, 0, 16'h0);
    // program D at 0x080
    mem[32] = enc(3, 1, 0, 16'h0);
    mem[33] = enc(4, 1, 0, 16'h0);
    mem[34] = enc(5, 0, 0, 16'h0A0);
    mem[35] = enc(1, 1, 0, 16'h154);
    mem[36] = enc(0, 1, 0, 16'h158);
    mem[37] = enc(4, 1, 0, 16'h0);
    mem[38] = enc(5, 0, 0, 16'h0A0);
    mem[39] = enc(1, 1, 0, 16'h15C);
    mem[40] = enc(6, 0, 0, 16'h0);
    // program E at 0x0C0
    mem[48] = enc(0, 2, 0, 16'h160);
    mem[49] = enc(0, 2, 1, 16'h0);
    mem[50] = enc(1, 2, 0, 16'h168);
    mem[51] = enc(6, 0, 0, 16'h0);
    // data
    mem[64] = 32'd5;            // 0x100 count
    mem[66] = 32'h200;          // 0x108 list base
    mem[128] = 32'd10; mem[129] = 32'd20; mem[130] = -32'sd5;
    mem[131] = 32'd7;  mem[132] = 32'd100;
    mem[80] = 32'h7FFF_FFFF;    // 0x140
    mem[81] = 32'd1;            // 0x144
    mem[82] = 32'hFFFF_FFFF;    // 0x148
    mem[83] = 32'd1;            // 0x14C
    mem[86] = 32'h8000_0000;    // 0x158
    mem[88] = 32'h164;          // 0x160
    mem[89] = 32'h55;           // 0x164

    repeat (3) @(negedge clk);
    chk("R12 reset pc", 32'(pc), 32'h0);
    chk("R12 reset flags", 32'(flags), 32'h0);
    chk("R12 reset halted", 32'(halted), 32'h0);
    chk("R11 reset bus", {30'd0, mem_rd, mem_wr}, 32'h0);
    rst_n = 1'b1;

    // R5 R6 R7 R8 R9: list sum loop
    expect_write(16'h104, 32'd132);
    expect_write(16'h10C, 32'h214);
    run(16'h0000, frd, fad);
    chk("R1 first fetch rd", 32'(frd), 32'h1);
    chk("R1 first fetch addr", 32'(fad), 32'h0);
    chk("R3 R10 pc after sum", 32'(pc), 32'h24);
    chk("R5 flags after store", 32'(flags), 32'h0);
    chk("R6 sum stored", mem[65], 32'd132);
    pc_h = pc;
    repeat (6) @(negedge clk);
    chk("R10 halted stays", 32'(halted), 32'h1);
    chk("R10 pc frozen", 32'(pc), 32'(pc_h));

    // R6 overflow, R8 not taken on N, flags kept
    run(16'h0040, frd, fad);
    chk("R6 overflow flags", 32'(flags), 32'hA);
    chk("R8 fallthrough pc", 32'(pc), 32'h50);

    // R6 carry and zero, R8 not taken on Z
    expect_write(16'h150, 32'hFFFF_FFFF);
    run(16'h0060, frd, fad);
    chk("R6 carry zero flags", 32'(flags), 32'h5);
    chk("R8 fallthrough on Z pc", 32'(pc), 32'h74);

    // R7 decrement corners, R8 taken branch skips a store
    expect_write(16'h154, 32'hFFFF_FFFF);
    run(16'h0080, frd, fad);
    chk("R7 dec of min flags", 32'(flags), 32'h3);
    chk("R8 taken pc", 32'(pc), 32'hA4);
    chk("R8 skipped store", mem[87], 32'h0);

    // R9 indirect with R2 as destination; R1 unaligned start
    expect_write(16'h168, 32'h55);
    run(16'h00C2, frd, fad);
    chk("R1 aligned entry", 32'(fad), 32'hC0);
    chk("R9 dest wins", mem[90], 32'h55);
    chk("R4 R10 pc end", 32'(pc), 32'hD0);

    repeat (2) @(negedge clk);
    chk("R5 scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 global watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule